// File: doc/BRIEF.md
# DMA Channel Register Set with Staged-Pair Autoload

This block holds the software-visible state of one DMA channel and runs its address and byte-count bookkeeping. A 32-bit register port reaches three words: a control/status word, a transfer address and a byte count. A bus-side stub reports each completed transfer beat together with the number of bytes it moved. On every accepted beat the channel adds those bytes to the address and, when counting is enabled, subtracts them from the count. The channel exports the current address, the transfer direction and the burst size so that the stub knows what to fetch next.

The address and count offsets each hold two registers. The visible one is the current pair. Hidden behind it is a staged (next) pair. A control bit decides which of the two a write reaches. Reads always return the current pair. When the count reaches zero, the channel raises terminal count and may raise an interrupt. If a staged pair is waiting and both autoload and counting are enabled, the staged pair becomes current on that same clock edge and transfers carry on without a gap. Otherwise the channel stops until the control word is written again with the DMA-enable bit set.

A self-clearing-by-software channel reset bit holds the whole engine idle. It cannot be released while the stub still reports an outstanding cycle.

Top module: `xfer_channel`

## Requirements
- R1: After `rst`, the control/status word reads 0xC in bits 31:28 (a fixed device code). Bit 10 mirrors `cyc_pending`. Every other bit reads 0, and the address and count words read 0.
- R2: Register words sit at byte offsets 0 (control/status), 4 (address) and 8 (count). Read data appears on `reg_rdata` one clock after `reg_addr` is presented. Offset 12 reads 0. A write to an address whose two low bits are non-zero is ignored.
- R3: When bit 24 (next-enable) is 0, writes to offsets 4 and 8 load the current address and count, and an address write sets bit 26. When bit 24 is 1, they load the staged pair instead, an address write sets bit 27, and the current readback is unchanged.
- R4: While bit 25 (channel running) is 1, each beat adds `beat_bytes` to the address. With bit 13 (count enable) set, the count drops by `beat_bytes`, floored at 0. With bit 13 clear, the count is unchanged.
- R5: Bit 25 is 1 exactly when bit 9 (DMA enable) is set, the channel is not in reset and the channel has not stopped. Beats received while bit 25 is 0 change nothing. A control write with bit 9 set clears a stop.
- R6: A beat that takes a non-zero count to 0 with bit 13 set raises bit 14 (terminal count). It also raises bit 0 (interrupt pending) unless bit 23 is set. Writing 1 to bit 14 clears both bits; writing 0 leaves them.
- R7: `irq` is high exactly when bit 0 and bit 4 (interrupt enable) are both 1.
- R8: When terminal count occurs with bits 24, 13 and 27 all set, the staged pair becomes current on that edge. Bit 27 clears, bit 26 stays 1, bit 25 stays 1, and the next beat advances from the staged address. When terminal count occurs without a staged pair, bit 25 drops.
- R9: With bit 24 set and bit 13 clear, no autoload ever happens: the staged address stays pending with bit 27 set while beats advance the current address.
- R10: Writing 1 to bit 7 puts the channel in reset. This clears both pairs, bits 0, 14, 25, 26 and 27, and makes address/count writes ignored. Writing 0 releases it at once if `cyc_pending` is low. Otherwise the release happens on the first clock with `cyc_pending` low.
- R11: `dir_to_mem` follows bit 8 (1 = device to memory) and `burst_code` follows bits 19:18. `burst_words` decodes the burst code as follows: 00 gives 4, 01 gives 8, 10 gives 1 and 11 gives 16 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | REG_AW (4) | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| beat_valid | input | 1 | Stub reports one completed beat |
| beat_bytes | input | BEAT_W (7) | Bytes moved by the beat |
| cyc_pending | input | 1 | Stub has an outstanding bus cycle |
| xfer_addr | output | 32 | Current transfer address |
| xfer_on | output | 1 | Channel running (accepts beats) |
| dir_to_mem | output | 1 | 1 = device to memory, 0 = memory to device |
| burst_code | output | 2 | Raw burst-size field |
| burst_words | output | 5 | Decoded burst length in words |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a terminal count that lands exactly while a staged pair is waiting. In that case the swap, the flag hand-off and the uninterrupted run must all happen on one edge. The stimulus reaches it by writing the current pair, then turning on next-enable so that the same offsets now reach the staged pair, and then driving beats whose sizes sum exactly to the loaded count. A sweep over all beat sizes from 1 to 16 also checks the saturating count arithmetic on exact and overshooting final beats. Along the way, the sweep varies interrupt enable and interrupt suppression.

// File: rtl/xfer_chan_pkg.sv
package xfer_chan_pkg;

  localparam int WORD_BITS = 32;

  // control/status bit positions (software decodes these)
  localparam int B_IPEND  = 0;
  localparam int B_IEN    = 4;
  localparam int B_CRST   = 7;
  localparam int B_DIR    = 8;
  localparam int B_DEN    = 9;
  localparam int B_CYC    = 10;
  localparam int B_CEN    = 13;
  localparam int B_TC     = 14;
  localparam int B_BLO    = 18;
  localparam int B_TCIDIS = 23;
  localparam int B_NEN    = 24;
  localparam int B_ON     = 25;
  localparam int B_AL     = 26;
  localparam int B_NAL    = 27;

  // bits stored as plain read/write control fields
  localparam logic [WORD_BITS-1:0] CTL_WMASK = 32'h01CD_2310;
  localparam logic [3:0]           DEV_CODE  = 4'hC;

  typedef enum logic [1:0] {
    SEL_CSR  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic logic [4:0] decode_burst(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd4;
      2'b01:   return 5'd8;
      2'b10:   return 5'd1;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/xfer_ctrl_regs.sv
module xfer_ctrl_regs
  import xfer_chan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csr_wr,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic                 cyc_pending,
  output logic [WORD_BITS-1:0] ctl_q,
  output logic                 chan_rst,
  output logic                 tc_clr,
  output logic                 rearm
);

  logic rel_wait;

  assign tc_clr = csr_wr & wdata[B_TC];
  assign rearm  = csr_wr & wdata[B_DEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      chan_rst <= 1'b0;
      rel_wait <= 1'b0;
    end else begin
      if (csr_wr) begin
        ctl_q <= (ctl_q & ~CTL_WMASK) | (wdata & CTL_WMASK);
        if (wdata[B_CRST]) begin
          chan_rst <= 1'b1;
          rel_wait <= 1'b0;
        end else if (chan_rst) begin
          if (cyc_pending) rel_wait <= 1'b1;
          else begin
            chan_rst <= 1'b0;
            rel_wait <= 1'b0;
          end
        end
      end else if (rel_wait && !cyc_pending) begin
        chan_rst <= 1'b0;
        rel_wait <= 1'b0;
      end
    end
  end

  // R10: an outstanding cycle keeps the channel in reset
  assert_hold_reset_R10: assert property (@(posedge clk) disable iff (rst)
    (chan_rst && cyc_pending) |=> chan_rst);

  // R10: writing 1 to the reset bit always enters reset
  assert_enter_reset_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && wdata[B_CRST]) |=> chan_rst);

endmodule

// File: rtl/xfer_addr_engine.sv
module xfer_addr_engine #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int BW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_rst,
  input  logic          dma_en,
  input  logic          cnt_en,
  input  logic          next_en,
  input  logic          tci_dis,
  input  logic          rearm,
  input  logic          tc_clr,
  input  logic          addr_wr,
  input  logic          cnt_wr,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_cnt,
  input  logic          beat_valid,
  input  logic [BW-1:0] beat_bytes,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          tc,
  output logic          int_pend,
  output logic          a_loaded,
  output logic          na_loaded,
  output logic          dma_on
);

  logic [AW-1:0] nxt_addr;
  logic [CW-1:0] nxt_cnt;
  logic          stopped;
  logic          take;
  logic          hits_zero;
  logic          reload;
  logic [CW-1:0] bytes_c;
  logic [CW-1:0] step_cnt;

  assign dma_on  = dma_en & ~chan_rst & ~stopped;
  assign take    = dma_on & beat_valid;
  assign bytes_c = CW'(beat_bytes);

  always_comb begin
    hits_zero = cnt_en && (cur_cnt != '0) && (bytes_c >= cur_cnt);
    reload    = hits_zero && next_en && na_loaded;
    if (!cnt_en)                step_cnt = cur_cnt;
    else if (bytes_c >= cur_cnt) step_cnt = '0;
    else                         step_cnt = cur_cnt - bytes_c;
  end

  always_ff @(posedge clk) begin
    if (rst || chan_rst) begin
      cur_addr  <= '0;
      cur_cnt   <= '0;
      nxt_addr  <= '0;
      nxt_cnt   <= '0;
      tc        <= 1'b0;
      int_pend  <= 1'b0;
      a_loaded  <= 1'b0;
      na_loaded <= 1'b0;
      stopped   <= 1'b0;
    end else begin
      if (rearm) stopped <= 1'b0;
      if (tc_clr) begin
        tc       <= 1'b0;
        int_pend <= 1'b0;
      end
      if (take) begin
        cur_addr <= cur_addr + AW'(beat_bytes);
        cur_cnt  <= step_cnt;
        if (hits_zero) begin
          tc <= 1'b1;
          if (!tci_dis) int_pend <= 1'b1;
          if (reload) begin
            cur_addr  <= nxt_addr;
            cur_cnt   <= nxt_cnt;
            na_loaded <= 1'b0;
            a_loaded  <= 1'b1;
          end else begin
            stopped <= 1'b1;
          end
        end
      end
      if (addr_wr) begin
        if (next_en) begin
          nxt_addr  <= wr_addr;
          na_loaded <= 1'b1;
        end else begin
          cur_addr <= wr_addr;
          a_loaded <= 1'b1;
        end
      end
      if (cnt_wr) begin
        if (next_en) nxt_cnt <= wr_cnt;
        else         cur_cnt <= wr_cnt;
      end
    end
  end

  // R4: uncounted beat advances the address by the bytes moved
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (dma_on && beat_valid && !cnt_en && !addr_wr && !chan_rst)
      |=> cur_addr == $past(cur_addr + AW'(beat_bytes)));

  // R6: final beat raises terminal count and the pending flag
  assert_tc_raise_R6: assert property (@(posedge clk) disable iff (rst)
    (dma_on && beat_valid && cnt_en && cur_cnt != '0 && CW'(beat_bytes) >= cur_cnt && !tci_dis)
      |=> (tc && int_pend));

  // R8: autoload swaps in the staged address and clears its flag
  assert_autoload_R8: assert property (@(posedge clk) disable iff (rst)
    (dma_on && beat_valid && cnt_en && next_en && na_loaded && cur_cnt != '0 &&
     CW'(beat_bytes) >= cur_cnt && !addr_wr)
      |=> (cur_addr == $past(nxt_addr) && !na_loaded && dma_on));

  // R9: without counting, the staged pair is never consumed
  assert_no_reload_R9: assert property (@(posedge clk) disable iff (rst)
    (na_loaded && !cnt_en && !chan_rst) |=> na_loaded);

endmodule

// File: rtl/xfer_readback.sv
module xfer_readback
  import xfer_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  reg_sel_e             sel,
  input  logic [WORD_BITS-1:0] ctl_q,
  input  logic                 chan_rst,
  input  logic                 cyc_pending,
  input  logic                 int_pend,
  input  logic                 tc,
  input  logic                 dma_on,
  input  logic                 a_loaded,
  input  logic                 na_loaded,
  input  logic [AW-1:0]        cur_addr,
  input  logic [CW-1:0]        cur_cnt,
  output logic [WORD_BITS-1:0] rdata
);

  logic [WORD_BITS-1:0] csr_word;

  always_comb begin
    csr_word           = ctl_q;
    csr_word[B_IPEND]  = int_pend;
    csr_word[B_CRST]   = chan_rst;
    csr_word[B_CYC]    = cyc_pending;
    csr_word[B_TC]     = tc;
    csr_word[B_ON]     = dma_on;
    csr_word[B_AL]     = a_loaded;
    csr_word[B_NAL]    = na_loaded;
    csr_word[31:28]    = DEV_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (sel)
        SEL_CSR:  rdata <= csr_word;
        SEL_ADDR: rdata <= WORD_BITS'(cur_addr);
        SEL_CNT:  rdata <= WORD_BITS'(cur_cnt);
        default:  rdata <= '0;
      endcase
    end
  end

  // R1: control word always carries the device code
  assert_dev_code_R1: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_CSR) |=> (rdata[31:28] == DEV_CODE));

  // R2: unmapped offset reads zero
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (rdata == '0));

endmodule

// File: rtl/xfer_channel.sv
module xfer_channel
  import xfer_chan_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              cyc_pending,
  output logic [31:0]       xfer_addr,
  output logic              xfer_on,
  output logic              dir_to_mem,
  output logic [1:0]        burst_code,
  output logic [4:0]        burst_words,
  output logic              irq
);

  localparam int IDX_W = REG_AW - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;
  reg_sel_e         sel;
  logic [31:0]      ctl_q;
  logic             chan_rst, tc_clr, rearm;
  logic             tc, int_pend, a_loaded, na_loaded, dma_on;
  logic [CNT_W-1:0] cur_cnt;

  assign word_idx = reg_addr[REG_AW-1:2];
  assign aligned  = (reg_addr[1:0] == 2'b00);

  always_comb begin
    if (!aligned)                     sel = SEL_NONE;
    else if (word_idx == IDX_W'(0))   sel = SEL_CSR;
    else if (word_idx == IDX_W'(1))   sel = SEL_ADDR;
    else if (word_idx == IDX_W'(2))   sel = SEL_CNT;
    else                              sel = SEL_NONE;
  end

  xfer_ctrl_regs u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .csr_wr      (reg_we && sel == SEL_CSR),
    .wdata       (reg_wdata),
    .cyc_pending (cyc_pending),
    .ctl_q       (ctl_q),
    .chan_rst    (chan_rst),
    .tc_clr      (tc_clr),
    .rearm       (rearm)
  );

  xfer_addr_engine #(.AW(32), .CW(CNT_W), .BW(BEAT_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .chan_rst   (chan_rst),
    .dma_en     (ctl_q[B_DEN]),
    .cnt_en     (ctl_q[B_CEN]),
    .next_en    (ctl_q[B_NEN]),
    .tci_dis    (ctl_q[B_TCIDIS]),
    .rearm      (rearm),
    .tc_clr     (tc_clr),
    .addr_wr    (reg_we && sel == SEL_ADDR),
    .cnt_wr     (reg_we && sel == SEL_CNT),
    .wr_addr    (reg_wdata),
    .wr_cnt     (reg_wdata[CNT_W-1:0]),
    .beat_valid (beat_valid),
    .beat_bytes (beat_bytes),
    .cur_addr   (xfer_addr),
    .cur_cnt    (cur_cnt),
    .tc         (tc),
    .int_pend   (int_pend),
    .a_loaded   (a_loaded),
    .na_loaded  (na_loaded),
    .dma_on     (dma_on)
  );

  xfer_readback #(.AW(32), .CW(CNT_W)) u_rdback (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .ctl_q       (ctl_q),
    .chan_rst    (chan_rst),
    .cyc_pending (cyc_pending),
    .int_pend    (int_pend),
    .tc          (tc),
    .dma_on      (dma_on),
    .a_loaded    (a_loaded),
    .na_loaded   (na_loaded),
    .cur_addr    (xfer_addr),
    .cur_cnt     (cur_cnt),
    .rdata       (reg_rdata)
  );

  assign xfer_on     = dma_on;
  assign dir_to_mem  = ctl_q[B_DIR];
  assign burst_code  = ctl_q[B_BLO+1:B_BLO];
  assign burst_words = decode_burst(ctl_q[B_BLO+1:B_BLO]);
  assign irq         = int_pend & ctl_q[B_IEN];

endmodule

// File: tb/test_xfer_channel.sv
module test_xfer_channel;

  localparam logic [31:0] IEN    = 32'h1 << 4;
  localparam logic [31:0] CRST   = 32'h1 << 7;
  localparam logic [31:0] DIRB   = 32'h1 << 8;
  localparam logic [31:0] DEN    = 32'h1 << 9;
  localparam logic [31:0] CEN    = 32'h1 << 13;
  localparam logic [31:0] TCB    = 32'h1 << 14;
  localparam logic [31:0] TCIDIS = 32'h1 << 23;
  localparam logic [31:0] NEN    = 32'h1 << 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        beat_valid = 1'b0;
  logic [6:0]  beat_bytes = '0;
  logic        cyc_pending = 1'b0;
  logic [31:0] xfer_addr;
  logic        xfer_on, dir_to_mem, irq;
  logic [1:0]  burst_code;
  logic [4:0]  burst_words;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  xfer_channel i_xfer_channel (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_valid(beat_valid),
    .beat_bytes(beat_bytes), .cyc_pending(cyc_pending), .xfer_addr(xfer_addr),
    .xfer_on(xfer_on), .dir_to_mem(dir_to_mem), .burst_code(burst_code),
    .burst_words(burst_words), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic beat(input int n);
    @(negedge clk);
    beat_valid = 1'b1; beat_bytes = 7'(n);
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'd0, v);  chk("R1 csr after reset", v, 32'hC000_0000);
    rd(4'd4, v);  chk("R1 addr after reset", v, 0);
    rd(4'd8, v);  chk("R1 count after reset", v, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 xfer_on after reset", {31'b0, xfer_on}, 0);
    rd(4'd12, v); chk("R2 offset 12 reads zero", v, 0);

    // R11 burst and direction sweep
    for (int b = 0; b < 4; b++) begin
      logic [4:0] ew;
      ew = (b == 0) ? 5'd4 : (b == 1) ? 5'd8 : (b == 2) ? 5'd1 : 5'd16;
      wr(4'd0, (32'(b) << 18) | ((b % 2 == 1) ? DIRB : 32'h0));
      chk("R11 burst_code", {30'b0, burst_code}, 32'(b));
      chk("R11 burst_words", {27'b0, burst_words}, {27'b0, ew});
      chk("R11 dir_to_mem", {31'b0, dir_to_mem}, 32'(b % 2));
      rd(4'd0, v);
      chk("R11 burst field readback", {30'b0, v[19:18]}, 32'(b));
    end

    // R4 R5 R6 R7 sweep of beat sizes with counting
    for (int s = 1; s <= 16; s++) begin
      logic [31:0] ctl, base;
      int cnt, rem, nb;
      ctl  = DEN | CEN | ((s % 2 == 0) ? IEN : 32'h0) | ((s % 4 == 3) ? TCIDIS : 32'h0);
      base = 32'h100 * s;
      cnt  = 5 * s + (s % 3);
      wr(4'd0, ctl | TCB);
      wr(4'd4, base);
      wr(4'd8, 32'(cnt));
      rem = cnt; nb = 0;
      while (rem > 0) begin
        beat(s);
        rem = (rem > s) ? rem - s : 0;
        nb++;
      end
      beat(s); // R5: ignored once stopped
      rd(4'd4, v); chk("R4 R5 address after run", v, base + 32'(nb * s));
      rd(4'd8, v); chk("R4 count floored at zero", v, 0);
      rd(4'd0, v);
      chk("R6 terminal count set", {31'b0, v[14]}, 1);
      chk("R6 pending unless suppressed", {31'b0, v[0]}, (s % 4 == 3) ? 0 : 1);
      chk("R5 stopped after terminal count", {31'b0, v[25]}, 0);
      chk("R7 irq", {31'b0, irq}, ((s % 4 != 3) && (s % 2 == 0)) ? 1 : 0);
      wr(4'd0, ctl);
      rd(4'd0, v);
      chk("R6 writing 0 keeps terminal count", {31'b0, v[14]}, 1);
      wr(4'd0, ctl | TCB);
      rd(4'd0, v);
      chk("R6 terminal count cleared", {31'b0, v[14]}, 0);
      chk("R6 pending cleared", {31'b0, v[0]}, 0);
      chk("R7 irq low after clear", {31'b0, irq}, 0);
      chk("R5 control write re-arms", {31'b0, v[25]}, 1);
    end

    // R4 counting disabled, R2 misaligned write ignored, R3 direct load flag
    wr(4'd0, DEN);
    wr(4'd4, 32'h4000);
    wr(4'd8, 32'd10);
    wr(4'd5, 32'h9999);
    rd(4'd4, v); chk("R2 misaligned write ignored", v, 32'h4000);
    rd(4'd0, v); chk("R3 address-loaded flag", {31'b0, v[26]}, 1);
    for (int k = 0; k < 5; k++) beat(4);
    rd(4'd4, v); chk("R4 address advance uncounted", v, 32'h4014);
    rd(4'd8, v); chk("R4 count unchanged uncounted", v, 10);
    rd(4'd0, v); chk("R4 no terminal count uncounted", {31'b0, v[14]}, 0);

    // R3 R8 aliasing and autoload
    wr(4'd0, DEN | CEN | TCB);
    wr(4'd4, 32'h2000);
    wr(4'd8, 32'd8);
    wr(4'd0, DEN | CEN | NEN);
    wr(4'd4, 32'h3000);
    wr(4'd8, 32'd12);
    rd(4'd4, v); chk("R3 staged write leaves current address", v, 32'h2000);
    rd(4'd8, v); chk("R3 staged write leaves current count", v, 8);
    rd(4'd0, v); chk("R3 next-loaded flag", {31'b0, v[27]}, 1);
    beat(4); beat(4);
    rd(4'd4, v); chk("R8 staged address now current", v, 32'h3000);
    rd(4'd8, v); chk("R8 staged count now current", v, 12);
    rd(4'd0, v);
    chk("R8 next-loaded cleared", {31'b0, v[27]}, 0);
    chk("R8 address-loaded kept", {31'b0, v[26]}, 1);
    chk("R8 still running", {31'b0, v[25]}, 1);
    chk("R8 terminal count on swap", {31'b0, v[14]}, 1);
    beat(4);
    rd(4'd4, v); chk("R8 continues from staged address", v, 32'h3004);
    rd(4'd8, v); chk("R8 continues from staged count", v, 8);
    beat(4); beat(4);
    rd(4'd0, v); chk("R8 stops with nothing staged", {31'b0, v[25]}, 0);
    rd(4'd4, v); chk("R8 final address", v, 32'h300C);

    // R9 next-enable without counting
    wr(4'd0, DEN | NEN);
    wr(4'd4, 32'h5000);
    beat(2); beat(2);
    rd(4'd4, v); chk("R9 current address advances", v, 32'h3010);
    rd(4'd0, v); chk("R9 staged pair stays pending", {31'b0, v[27]}, 1);

    // R1 R10 channel reset and release
    cyc_pending = 1'b1;
    rd(4'd0, v); chk("R1 cycle-pending mirror", {31'b0, v[10]}, 1);
    wr(4'd0, CRST | DEN);
    rd(4'd4, v); chk("R10 reset clears address", v, 0);
    rd(4'd0, v);
    chk("R10 reset bit set", {31'b0, v[7]}, 1);
    chk("R10 next flag cleared", {31'b0, v[27]}, 0);
    chk("R10 address flag cleared", {31'b0, v[26]}, 0);
    chk("R10 not running in reset", {31'b0, v[25]}, 0);
    wr(4'd4, 32'h7777);
    rd(4'd4, v); chk("R10 writes ignored in reset", v, 0);
    wr(4'd0, DEN);
    rd(4'd0, v); chk("R10 release held while pending", {31'b0, v[7]}, 1);
    @(negedge clk) cyc_pending = 1'b0;
    @(negedge clk);
    rd(4'd0, v);
    chk("R10 released after pending drops", {31'b0, v[7]}, 0);
    chk("R10 running after release", {31'b0, v[25]}, 1);
    wr(4'd0, CRST);
    wr(4'd0, 32'h0);
    rd(4'd0, v); chk("R10 immediate release when idle", {31'b0, v[7]}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule